// File: doc/BRIEF.md
# Scaled Compare Watchdog Timer

This block is a watchdog for an always-on power domain. It is clocked by the domain clock and advances on a slow clock-enable tick. A 31-bit counter runs while either of two enable bits in the configuration register is set. A 16-bit window of the counter, selected by a 4-bit right shift, is compared against a programmable threshold.

A compare hit does three things. It sets a sticky interrupt-pending bit, which drives the interrupt output. When zero-on-compare is set, it clears the counter, so the block works as a periodic timer. When reset-enable is set, it raises a one-cycle reset request.

Software reaches the block through a plain single-cycle register port with a combinational read path. Every write other than a write to the key register is protected by a lock. A small state machine has two states: `LK_SHUT` (writes ignored) and `LK_OPEN` (the next write is accepted). It makes these transitions:
- `SHUT->OPEN` on a key write with the unlock value.
- `OPEN->OPEN` on another correct key write.
- `OPEN->SHUT` on a key write with any other value.
- `OPEN->SHUT` on any non-key write. That write is applied.
- `SHUT->SHUT` otherwise.

Top module: `aon_wdog`

## Requirements
- R1: On a cycle with `tick_i` high, the counter increments by one if enable-always (config bit 12) or enable-core-awake (config bit 13) is set. When both bits are clear, the count holds.
- R2: The counter is 31 bits wide. Reading the count register (byte offset 0x08) returns it with bit 31 always zero. Incrementing from 0x7FFFFFFF gives 0.
- R3: The scaled register (offset 0x10) reads as the counter shifted right by the scale field (config bits 3:0), truncated to 16 bits, with bits 31:16 zero.
- R4: A compare hit exists in any cycle where the scaled value is greater than or equal to the 16-bit compare register (offset 0x20, bits 15:0).
- R5: A hit sets interrupt-pending (config bit 28) on the next clock, and the bit stays set. `irq_o` equals that bit. An accepted config write loads bit 28 from the write data, but a hit in the same cycle keeps it set.
- R6: When zero-on-compare (config bit 9) is set, a hit clears the counter on the next clock.
- R7: When reset-enable (config bit 8) is set, `rst_req_o` pulses high for exactly one cycle. The pulse comes one clock after the first cycle of each unbroken run of hit cycles.
- R8: Writing 0x0051F15E to the key register (offset 0x1C) unlocks the block. The next write to any other offset is applied and locks it again. A key write with another value locks it. Writes to other offsets while locked are ignored. Writes to the scaled register never change state, but they still lock.
- R9: An accepted write of 0x0D09F00D to the feed register (offset 0x18) clears the counter. Any other value written there leaves the count unchanged.
- R10: After reset, the following values hold:
  - configuration and count read 0;
  - the compare register reads 0xFFFF;
  - `irq_o` and `rst_req_o` are low;
  - the block is locked;
  - unmapped offsets read 0.
- R11: When several counter updates apply in the same cycle, the highest-priority one wins. The order, highest first, is: an accepted count write (loads write-data bits 30:0), then a feed clear, then a zero-on-compare clear, then the tick increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow clock-enable tick for the counter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt, equal to the pending bit |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with `CNT_W = 31` and `CMP_W = 16`. With these values, writing a count near 0x7FFFFFFF reaches the 31-bit wrap in a few dozen ticks. The same values let small compare thresholds combined with scale shifts of 0 to 3 exercise the scaled window and the periodic zero-on-compare mode within a short run. A compare value of zero keeps the hit asserted continuously. This exposes the single-pulse reset request and the priority of a count write over the zero-on-compare clear.

// File: rtl/aon_wdog_pkg.sv
package aon_wdog_pkg;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned SCALE_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_SCALED = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_FEED   = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_CMP    = 6'h20;

    localparam int unsigned BIT_RSTEN  = 8;
    localparam int unsigned BIT_ZCMP   = 9;
    localparam int unsigned BIT_EN_ALW = 12;
    localparam int unsigned BIT_EN_AWK = 13;
    localparam int unsigned BIT_IP     = 28;

    typedef struct packed {
        logic               ip;
        logic               en_awk;
        logic               en_alw;
        logic               zcmp;
        logic               rsten;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

endpackage

// File: rtl/aon_wdog_lock.sv
module aon_wdog_lock
    import aon_wdog_pkg::*;
#(
    parameter logic [REG_W-1:0] KEY_VAL = 32'h0051_F15E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic              wr_ok_o,
    output logic              open_o
);

    lock_state_e state_q, state_d;
    logic        key_hit;

    assign key_hit = we_i && (addr_i == OFF_KEY) && (wdata_i == KEY_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SHUT: if (key_hit) state_d = LK_OPEN;
            LK_OPEN: if (we_i)    state_d = key_hit ? LK_OPEN : LK_SHUT;
            default:              state_d = LK_SHUT;
        endcase
    end

    always_comb begin
        open_o  = (state_q == LK_OPEN);
        wr_ok_o = we_i && (addr_i != OFF_KEY) && (state_q == LK_OPEN);
    end

endmodule

// File: rtl/aon_wdog_count.sv
module aon_wdog_count #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_o <= '0;
        else if (load_i)         cnt_o <= load_val_i;
        else if (clr_i)          cnt_o <= '0;
        else if (tick_i && run_i) cnt_o <= cnt_o + ONE;
    end

endmodule

// File: rtl/aon_wdog_cmp.sv
module aon_wdog_cmp
    import aon_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 31,
    parameter int unsigned CMP_W = 16
) (
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [CMP_W-1:0]   cmp_i,
    output logic [CMP_W-1:0]   scaled_o,
    output logic               hit_o
);

    logic [CNT_W-1:0] shifted;

    assign shifted = cnt_i >> scale_i;

    generate
        if (CMP_W <= CNT_W) begin : g_slice
            assign scaled_o = shifted[CMP_W-1:0];
        end else begin : g_pad
            assign scaled_o = {{(CMP_W-CNT_W){1'b0}}, shifted};
        end
    endgenerate

    assign hit_o = (scaled_o >= cmp_i);

endmodule

// File: rtl/aon_wdog.sv
module aon_wdog
    import aon_wdog_pkg::*;
#(
    parameter int unsigned      CNT_W    = 31,
    parameter int unsigned      CMP_W    = 16,
    parameter logic [REG_W-1:0] KEY_VAL  = 32'h0051_F15E,
    parameter logic [REG_W-1:0] FEED_VAL = 32'h0D09_F00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    cfg_t             cfg_q;
    logic [CMP_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_w;
    logic [CMP_W-1:0] scaled_w;
    logic             hit_w, hit_q, rst_req_q;
    logic             wr_ok, lock_open_w;
    logic             ld_cnt, feed_clr, cnt_clr;

    aon_wdog_lock #(.KEY_VAL(KEY_VAL)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .wr_ok_o (wr_ok),
        .open_o  (lock_open_w)
    );

    assign ld_cnt   = wr_ok && (reg_addr_i == OFF_COUNT);
    assign feed_clr = wr_ok && (reg_addr_i == OFF_FEED) && (reg_wdata_i == FEED_VAL);
    assign cnt_clr  = feed_clr || (hit_w && cfg_q.zcmp);

    aon_wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (cfg_q.en_alw || cfg_q.en_awk),
        .load_i     (ld_cnt),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .clr_i      (cnt_clr),
        .cnt_o      (cnt_w)
    );

    aon_wdog_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
        .cnt_i    (cnt_w),
        .scale_i  (cfg_q.scale),
        .cmp_i    (cmp_q),
        .scaled_o (scaled_w),
        .hit_o    (hit_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ok && (reg_addr_i == OFF_CFG)) begin
            cfg_q.scale  <= reg_wdata_i[SCALE_W-1:0];
            cfg_q.rsten  <= reg_wdata_i[BIT_RSTEN];
            cfg_q.zcmp   <= reg_wdata_i[BIT_ZCMP];
            cfg_q.en_alw <= reg_wdata_i[BIT_EN_ALW];
            cfg_q.en_awk <= reg_wdata_i[BIT_EN_AWK];
            cfg_q.ip     <= reg_wdata_i[BIT_IP] | hit_w;
        end else begin
            cfg_q.ip     <= cfg_q.ip | hit_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q     <= '1;
            hit_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (wr_ok && (reg_addr_i == OFF_CMP)) cmp_q <= reg_wdata_i[CMP_W-1:0];
            hit_q     <= hit_w;
            rst_req_q <= hit_w && !hit_q && cfg_q.rsten;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            OFF_CFG: begin
                reg_rdata_o[SCALE_W-1:0] = cfg_q.scale;
                reg_rdata_o[BIT_RSTEN]   = cfg_q.rsten;
                reg_rdata_o[BIT_ZCMP]    = cfg_q.zcmp;
                reg_rdata_o[BIT_EN_ALW]  = cfg_q.en_alw;
                reg_rdata_o[BIT_EN_AWK]  = cfg_q.en_awk;
                reg_rdata_o[BIT_IP]      = cfg_q.ip;
            end
            OFF_COUNT:  reg_rdata_o[CNT_W-1:0] = cnt_w;
            OFF_SCALED: reg_rdata_o[CMP_W-1:0] = scaled_w;
            OFF_CMP:    reg_rdata_o[CMP_W-1:0] = cmp_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o     = cfg_q.ip;
    assign rst_req_o = rst_req_q;

endmodule

// File: rtl/aon_wdog_chk.sv
module aon_wdog_chk
    import aon_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 31,
    parameter int unsigned CMP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              irq_o,
    input logic              rst_req_o,
    input logic [CNT_W-1:0]  cnt,
    input logic              hit,
    input logic              en_alw,
    input logic              en_awk,
    input logic              zcmp,
    input logic              lock_open,
    input logic [CMP_W-1:0]  cmp_val
);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_alw && !en_awk && !reg_we_i && !(hit && zcmp)) |=> $stable(cnt)); // R1

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (en_alw || en_awk) && !reg_we_i && !(hit && zcmp) && (&cnt)) |=> (cnt == '0)); // R2

    AST_COUNT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == OFF_COUNT) |-> ((reg_rdata_o >> CNT_W) == '0)); // R2

    AST_IRQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_o); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(reg_we_i && (reg_addr_i == OFF_CFG))) |=> irq_o); // R5

    AST_ZERO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && zcmp && !(reg_we_i && lock_open && (reg_addr_i == OFF_COUNT))) |=> (cnt == '0)); // R6

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R7

    AST_LOCKED_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_open && reg_we_i) |=> $stable(cmp_val)); // R8

endmodule

bind aon_wdog aon_wdog_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o),
    .cnt         (cnt_w),
    .hit         (hit_w),
    .en_alw      (cfg_q.en_alw),
    .en_awk      (cfg_q.en_awk),
    .zcmp        (cfg_q.zcmp),
    .lock_open   (lock_open_w),
    .cmp_val     (cmp_q)
);

// File: tb/aon_wdog_tb_top.sv
module aon_wdog_tb_top;
    import aon_wdog_pkg::*;

    localparam logic [31:0] KEY  = 32'h0051_F15E;
    localparam logic [31:0] FEED = 32'h0D09_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;

    always #2 clk = ~clk;

    aon_wdog #(.CNT_W(31), .CMP_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .rst_req_o(rst_req)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    longint m_cnt = 0;
    int     m_scale = 0;
    int     m_cmp = 16'hFFFF;
    bit     m_rsten = 0, m_zc = 0, m_ea = 0, m_ec = 0, m_ip = 0;
    bit     m_open = 0, m_hitq = 0, m_rst = 0;

    function automatic longint m_scaled();
        return (m_cnt >> m_scale) & 64'hFFFF;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        logic [31:0] v = '0;
        case (a)
            OFF_CFG: begin
                v[3:0] = 4'(m_scale); v[8] = m_rsten; v[9] = m_zc;
                v[12] = m_ea; v[13] = m_ec; v[28] = m_ip;
            end
            OFF_COUNT:  v = 32'(m_cnt);
            OFF_SCALED: v = 32'(m_scaled());
            OFF_CMP:    v = 32'(m_cmp);
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(logic [5:0] a);
        case (a)
            OFF_CFG:    return "R5 cfg read";
            OFF_COUNT:  return "R2 count read";
            OFF_SCALED: return "R3 scaled read";
            OFF_CMP:    return "R8 cmp read";
            default:    return "R10 unmapped read";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic step(bit w, logic [5:0] a, logic [31:0] d, bit tk);
        bit hit = (m_scaled() >= longint'(m_cmp));
        bit ok  = w && (a != OFF_KEY) && m_open;
        // R11 priority: count write, feed, zero-on-compare, tick
        if (ok && a == OFF_COUNT)                  m_cnt = d & 32'h7FFF_FFFF;
        else if (ok && a == OFF_FEED && d == FEED) m_cnt = 0;
        else if (hit && m_zc)                      m_cnt = 0;
        else if (tk && (m_ea || m_ec))             m_cnt = (m_cnt + 1) & 64'h7FFF_FFFF;
        m_rst  = hit && !m_hitq && m_rsten;
        m_hitq = hit;
        if (ok && a == OFF_CFG) begin
            m_scale = int'(d[3:0]); m_rsten = d[8]; m_zc = d[9];
            m_ea = d[12]; m_ec = d[13]; m_ip = d[28] | hit;
        end else begin
            m_ip = m_ip | hit;
        end
        if (ok && a == OFF_CMP) m_cmp = int'(d[15:0]);
        if (w) m_open = (a == OFF_KEY) && (d == KEY);
    endtask

    task automatic cyc(bit w, logic [5:0] a, logic [31:0] d, bit tk);
        we = w; addr = a; wdata = d; tick = tk;
        #1;
        check(tag_of(a), rdata, m_read(a));
        check("R5 irq_o", {31'b0, irq}, {31'b0, m_ip});
        check("R7 rst_req_o", {31'b0, rst_req}, {31'b0, m_rst});
        @(posedge clk);
        step(w, a, d, tk);
        @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        cyc(1'b1, OFF_KEY, KEY, 1'b0);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic run(logic [5:0] a, int n, int tick_every);
        for (int i = 0; i < n; i++) cyc(1'b0, a, '0, (i % tick_every) == 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values on every offset
        cyc(0, OFF_CFG, 0, 0);   cyc(0, OFF_COUNT, 0, 0); cyc(0, OFF_SCALED, 0, 0);
        cyc(0, OFF_CMP, 0, 0);   cyc(0, OFF_FEED, 0, 0);  cyc(0, 6'h3C, 0, 0);
        // R8: locked writes ignored, wrong key locks, scaled write re-locks
        cyc(1, OFF_CMP, 32'd5, 0);            cyc(0, OFF_CMP, 0, 0);
        cyc(1, OFF_KEY, 32'h123, 0);          cyc(1, OFF_CMP, 32'd7, 0);
        wr(OFF_SCALED, 32'hABCD);             cyc(1, OFF_CMP, 32'd9, 0);
        cyc(0, OFF_CMP, 0, 0);
        // R1 R4 R5: enable-always, compare at 12
        wr(OFF_CMP, 32'd12);
        wr(OFF_CFG, 32'h0000_1000);
        run(OFF_COUNT, 20, 1);
        // R5: clear attempt while hit persists, then real clear
        wr(OFF_CFG, 32'h0000_1000);           cyc(0, OFF_CFG, 0, 0);
        wr(OFF_CMP, 32'd4000);
        wr(OFF_CFG, 32'h0000_1000);           run(OFF_CFG, 3, 1);
        // R1: both enables off holds; enable-core-awake alone counts
        wr(OFF_CFG, 32'h0);                   run(OFF_COUNT, 10, 1);
        wr(OFF_CFG, 32'h0000_2000);           run(OFF_COUNT, 10, 2);
        // R3: scale 3
        wr(OFF_CFG, 32'h0000_2003);           run(OFF_SCALED, 40, 1);
        // R6 R7: periodic zero-on-compare with reset requests
        wr(OFF_COUNT, 32'h0);
        wr(OFF_CMP, 32'd4);
        wr(OFF_CFG, 32'h0000_1301);           run(OFF_COUNT, 40, 1);
        // R11 R7: compare 0 keeps hit high; count write beats the clear
        wr(OFF_CMP, 32'd0);                   run(OFF_COUNT, 4, 1);
        wr(OFF_COUNT, 32'd100);               run(OFF_COUNT, 4, 1);
        // R9: feed with wrong and right value
        wr(OFF_CFG, 32'h0000_1000);
        wr(OFF_CMP, 32'hFFFF);
        wr(OFF_COUNT, 32'd1000);              run(OFF_COUNT, 3, 1);
        wr(OFF_FEED, 32'h1234);               run(OFF_COUNT, 3, 1);
        wr(OFF_FEED, FEED);                   run(OFF_COUNT, 3, 1);
        // R2: wrap of the 31-bit count, top bit of the write dropped
        wr(OFF_COUNT, 32'hFFFF_FFF0);         run(OFF_COUNT, 25, 1);
        run(OFF_SCALED, 3, 1);
        finish_run();
    end

endmodule